// File: doc/BRIEF.md
# Serial Two-Wire Register Port (Slave Side)

This block lets an external two-wire (I2C) bus master read and write a bank of up to 256 byte-wide registers that sit inside the chip. It oversamples the clock and data lines on the system clock and recognises START and STOP conditions. It answers only to one fixed 7-bit bus address. The register file itself stays outside the block. The block presents a byte pointer, write data and a one-cycle write strobe, and it takes back the byte that the file returns for the current pointer.

A write transfer carries the address byte, then one byte that loads the register pointer, then any number of data bytes. Each data byte is written at the pointer, and the pointer then steps up by one. To read, the master first sets the pointer with a short write. It then issues a repeated START with the read direction and clocks bytes out from the pointer onward. The block only ever pulls the data line low, through an enable output. The pad and the pull-up resistor supply the high level.

Top module: `i2c_regport`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address matching in any state. A STOP (SDA rising while SCL is high) ends the transfer and releases SDA on the next cycle.
- R2: When the first 7 bits after START, MSB first, equal 7'b1101010 (group 1101, then device 010), the block pulls SDA low for the whole ninth clock. The eighth bit selects the direction: 0 is a write, 1 is a read.
- R3: For any other address, the block never pulls SDA, gives no write strobe and leaves the pointer unchanged until the next START.
- R4: After a matched write address, the next byte (MSB first) loads the register pointer, seen on `reg_addr_o`, and is acknowledged.
- R5: Each later byte of a write produces exactly one cycle of `reg_we_o`, with `reg_addr_o` set to the pointer and `reg_wdata_o` set to the byte. The pointer then increments by one and wraps from 8'hFF to 8'h00.
- R6: Every data byte of a write is acknowledged on its ninth clock.
- R7: On a read, the register at the pointer is shifted out MSB first, starting on the clock after the address acknowledge. SDA is pulled low for 0 bits and released for 1 bits.
- R8: When the master acknowledges a read byte (SDA low on the ninth clock), the pointer increments and the next register follows. After a NACK, the pointer is unchanged and SDA stays released until the next START.
- R9: A repeated START inside a byte discards the partial byte without a write strobe, keeps the pointer and restarts address matching.
- R10: The pull-low enable changes only while SCL is low. It is the block's only means of acting on SDA.
- R11: After reset, the pull-low enable and the write strobe are off and the pointer is 0. SCL and SDA pass through `SYNC_STAGES` (default 2) synchronizer flops before any decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least about 20 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low; 0 = release the line |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Byte to write |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Contents of the register at `reg_addr_o` |

## Verification
The bench drives several bus patterns. Multi-byte writes starting mid-bank and at 8'hFE tell pointer stepping apart from wrap-around. A write-pointer-then-repeated-START read shows that the pointer survives a restart, and its mixed 0/1 data checks bit order and the release on high bits. Two wrong addresses, one off in the device bits and one off in the group bits, tell a full 7-bit compare apart from a partial one. A START dropped into the middle of a data byte shows that a partial byte is thrown away. A NACK followed by extra clocks shows whether the slave really leaves the bus.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_SUB,
        PH_SUB_ACK,
        PH_WR,
        PH_WR_ACK,
        PH_RD,
        PH_RD_ACK
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   ptr;
        logic                rw;
        logic                mack;
        logic                pull;
        logic                we;
        logic [BYTE_W-1:0]   wdata;
    } eng_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its history
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic scl_lvl_i,
    input  logic sda_rise_i,
    input  logic sda_fall_i,
    output logic start_o,
    output logic stop_o
);
    always_comb begin
        start_o = sda_fall_i & scl_lvl_i;
        stop_o  = sda_rise_i & scl_lvl_i;
    end
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'b1101010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              pull_o,
    output logic [BYTE_W-1:0] ptr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o
);
    localparam logic [CNT_W-1:0] BITS_PER_BYTE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX_BIT   = CNT_W'(BYTE_W - 1);

    eng_state_t q, n;

    always_comb begin
        n    = q;
        n.we = 1'b0;
        if (q.we) n.ptr = q.ptr + 8'd1;

        if (stop_i) begin
            n.ph   = PH_IDLE;
            n.pull = 1'b0;
            n.cnt  = '0;
        end else if (start_i) begin
            n.ph   = PH_ADDR;
            n.pull = 1'b0;
            n.cnt  = '0;
        end else begin
            case (q.ph)
                PH_ADDR, PH_SUB, PH_WR: begin
                    if (scl_rise_i && q.cnt < BITS_PER_BYTE) begin
                        n.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == BITS_PER_BYTE) begin
                        n.cnt = '0;
                        if (q.ph == PH_ADDR) begin
                            if (q.sh[7:1] == SLAVE_ADDR) begin
                                n.ph   = PH_ADDR_ACK;
                                n.rw   = q.sh[0];
                                n.pull = 1'b1;
                            end else begin
                                n.ph   = PH_IDLE;
                            end
                        end else if (q.ph == PH_SUB) begin
                            n.ptr  = q.sh;
                            n.ph   = PH_SUB_ACK;
                            n.pull = 1'b1;
                        end else begin
                            n.we    = 1'b1;
                            n.wdata = q.sh;
                            n.ph    = PH_WR_ACK;
                            n.pull  = 1'b1;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        n.cnt = '0;
                        if (q.rw) begin
                            n.ph   = PH_RD;
                            n.sh   = rdata_i;
                            n.pull = ~rdata_i[BYTE_W-1];
                        end else begin
                            n.ph   = PH_SUB;
                            n.pull = 1'b0;
                        end
                    end
                end
                PH_SUB_ACK, PH_WR_ACK: begin
                    if (scl_fall_i) begin
                        n.ph   = PH_WR;
                        n.pull = 1'b0;
                        n.cnt  = '0;
                    end
                end
                PH_RD: begin
                    if (scl_fall_i) begin
                        if (q.cnt == LAST_TX_BIT) begin
                            n.ph   = PH_RD_ACK;
                            n.pull = 1'b0;
                            n.cnt  = '0;
                        end else begin
                            n.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                            n.pull = ~q.sh[BYTE_W-2];
                            n.cnt  = q.cnt + 4'd1;
                        end
                    end
                end
                PH_RD_ACK: begin
                    if (scl_rise_i) begin
                        n.mack = ~sda_i;
                        if (!sda_i) n.ptr = q.ptr + 8'd1;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            n.ph   = PH_RD;
                            n.sh   = rdata_i;
                            n.pull = ~rdata_i[BYTE_W-1];
                            n.cnt  = '0;
                        end else begin
                            n.ph   = PH_IDLE;
                            n.pull = 1'b0;
                        end
                    end
                end
                default: begin
                    n.ph   = PH_IDLE;
                    n.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
        end else begin
            q <= n;
        end
    end

    assign pull_o  = q.pull;
    assign ptr_o   = q.ptr;
    assign wdata_o = q.wdata;
    assign we_o    = q.we;
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] SLAVE_ADDR  = 7'b1101010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    localparam int N_LINES = 2;   // index 0: SCL, index 1: SDA

    logic [N_LINES-1:0] raw_w, lvl_w, rise_w, fall_w;
    logic scl_lvl, start_evt, stop_evt;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_w[g]),
            .level_o (lvl_w[g]),
            .rise_o  (rise_w[g]),
            .fall_o  (fall_w[g])
        );
    end

    assign scl_lvl = lvl_w[0];

    i2c_cond_detect u_cond (
        .scl_lvl_i  (scl_lvl),
        .sda_rise_i (rise_w[1]),
        .sda_fall_i (fall_w[1]),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2c_slave_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_evt),
        .stop_i     (stop_evt),
        .scl_rise_i (rise_w[0]),
        .scl_fall_i (fall_w[0]),
        .sda_i      (lvl_w[1]),
        .rdata_i    (reg_rdata_i),
        .pull_o     (sda_pull_o),
        .ptr_o      (reg_addr_o),
        .wdata_o    (reg_wdata_o),
        .we_o       (reg_we_o)
    );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull_o,
    input logic       reg_we_o,
    input logic [7:0] reg_addr_o,
    input logic       scl_lvl,
    input logic       start_evt,
    input logic       stop_evt
);
    assert_release_on_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull_o);

    assert_release_on_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_pull_o);

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> reg_addr_o == $past(reg_addr_o) + 8'd1);

    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_lvl);
endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .scl_lvl    (scl_lvl),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt)
);

// File: tb/test_i2c_regport.sv
module test_i2c_regport;
    localparam int Q = 10;   // system clocks per quarter bus bit

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst_n;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       sda_pull, reg_we, pull_prev;
    logic [7:0] reg_addr, reg_wdata, rdata;
    logic [7:0] regs [256];
    wire        sda_line = m_sda & ~sda_pull;

    int checks = 0, errors = 0, mptr = 0;
    logic [15:0] wq [$];

    assign rdata = regs[reg_addr];

    i2c_regport i_i2c_regport (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_we_o(reg_we), .reg_rdata_i(rdata)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // per-clock reference: register model, expected strobe queue, pull timing
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] = 8'((i * 37) ^ 8'h5A);
            pull_prev = 1'b0;
        end else begin
            if (reg_we) begin
                if (wq.size() == 0) begin
                    chk(0, "R5 unexpected write strobe", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = wq.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R5 write addr/data", {reg_addr, reg_wdata}, e);
                end
                regs[reg_addr] = reg_wdata;
            end
            if (sda_pull != pull_prev)
                chk(m_scl == 1'b0, "R10 pull change while SCL low", m_scl, 0);
            pull_prev = sda_pull;
        end
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic drive, output logic seen);
        m_sda = drive; wait_q(Q);
        m_scl = 1'b1;  wait_q(Q);
        seen  = sda_line; wait_q(Q);
        m_scl = 1'b0;  wait_q(Q);
    endtask

    task automatic start_c();
        m_sda = 1'b1; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b1; wait_q(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], s);
            chk(s == b[i], {req, " bus free during master bits"}, s, b[i]);
        end
        clk_bit(1'b1, s);
        chk(s == !exp_ack, {req, " ninth-clock acknowledge"}, s, !exp_ack);
    endtask

    task automatic read_byte(input bit mack, input string req);
        logic s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            got[i] = s;
        end
        chk(got == regs[mptr], {req, " read data"}, got, regs[mptr]);
        clk_bit(mack ? 1'b0 : 1'b1, s);
        if (mack) mptr = (mptr + 1) % 256;
    endtask

    task automatic write_txn(input logic [7:0] sub, input logic [31:0] bytes, input int n);
        start_c();
        send_byte(8'hD4, 1, "R2 write address");
        send_byte(sub, 1, "R4 subaddress");
        mptr = sub;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = bytes[31 - 8 * k -: 8];
            wq.push_back({8'(mptr), d});
            send_byte(d, 1, "R6 data byte");
            mptr = (mptr + 1) % 256;
        end
        stop_c();
        wait_q(4);
        chk(wq.size() == 0, "R5 all strobes seen", wq.size(), 0);
        chk(reg_addr == 8'(mptr), "R5 pointer after write", reg_addr, mptr);
    endtask

    initial begin
        logic s;
        rst_n = 1'b0;
        wait_q(5);
        rst_n = 1'b1;
        wait_q(4);
        chk(sda_pull == 1'b0, "R11 reset pull off", sda_pull, 0);
        chk(reg_we == 1'b0, "R11 reset strobe off", reg_we, 0);
        chk(reg_addr == 8'h00, "R11 reset pointer", reg_addr, 0);

        // R4 R5 R6: three bytes from 0x10
        write_txn(8'h10, 32'hA53CFF00, 3);

        // R7 R8 R9: set pointer, repeated START, read with ack/ack/nack
        start_c();
        send_byte(8'hD4, 1, "R2 write address");
        send_byte(8'h10, 1, "R4 subaddress");
        mptr = 8'h10;
        start_c();
        send_byte(8'hD5, 1, "R2 read address");
        read_byte(1, "R7");
        read_byte(1, "R8");
        read_byte(0, "R8");
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            chk(s == 1'b1, "R8 released after NACK", s, 1);
        end
        stop_c();
        wait_q(4);
        chk(reg_addr == 8'h12, "R8 pointer after acked bytes", reg_addr, 8'h12);

        // R3: wrong device bits, then wrong group bits
        start_c();
        send_byte(8'hD6, 0, "R3 wrong device");
        send_byte(8'h33, 0, "R3 ignored byte");
        send_byte(8'h00, 0, "R3 ignored byte");
        stop_c();
        start_c();
        send_byte(8'hC5, 0, "R3 wrong group");
        send_byte(8'hFF, 0, "R3 no read data");
        stop_c();
        wait_q(4);
        chk(reg_addr == 8'h12, "R3 pointer unchanged", reg_addr, 8'h12);
        chk(wq.size() == 0, "R3 no strobe", wq.size(), 0);

        // R5 wrap at 0xFF, then read back across the wrap
        write_txn(8'hFE, 32'h01020300, 3);
        start_c();
        send_byte(8'hD4, 1, "R2 write address");
        send_byte(8'hFF, 1, "R4 subaddress");
        mptr = 8'hFF;
        start_c();
        send_byte(8'hD5, 1, "R2 read address");
        read_byte(1, "R5 wrap read");
        read_byte(0, "R5 wrap read");
        stop_c();

        // R9: repeated START cuts a data byte in half
        start_c();
        send_byte(8'hD4, 1, "R2 write address");
        send_byte(8'h40, 1, "R4 subaddress");
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        start_c();
        send_byte(8'hD4, 1, "R9 address after restart");
        send_byte(8'h50, 1, "R4 subaddress");
        wq.push_back(16'h5077);
        send_byte(8'h77, 1, "R9 data after restart");
        stop_c();
        wait_q(4);
        chk(wq.size() == 0, "R9 only the full byte written", wq.size(), 0);
        chk(regs[8'h40] == 8'((8'h40 * 37) ^ 8'h5A), "R9 partial byte dropped", regs[8'h40], 8'((8'h40 * 37) ^ 8'h5A));
        chk(reg_addr == 8'h51, "R9 pointer", reg_addr, 8'h51);

        // R9: pointer kept across restart for a read
        start_c();
        send_byte(8'hD5, 1, "R9 read without new pointer");
        mptr = 8'h51;
        read_byte(0, "R9 read at kept pointer");
        stop_c();
        wait_q(4);
        chk(sda_pull == 1'b0, "R1 released after STOP", sda_pull, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule